// File: doc/BRIEF.md
# Decoupled SIMD Lane Issue Controller

This block feeds one SIMD instruction stream to a set of lanes. Each lane has its own shallow control queue. When a lane detects a timing error it recovers by stalling in place. It stops taking instructions from its queue while the other lanes keep draining theirs. Lanes drift apart by at most the queue depth.

Some points in the stream need the lanes back in lockstep. At such a point the controller holds the instruction back until every queue is empty and no lane is stalled. It then broadcasts the instruction to all lanes together. An instruction marked as a synchronisation point always forces this realignment. A configuration pin decides whether memory instructions force it as well.

The upstream interface is valid/ready. An instruction moves only in a cycle where `in_valid` and `in_ready` are both high. While `in_ready` is low the producer must hold the instruction and its flags steady. Each lane interface is also valid/ready. A lane drops `lane_ready` to apply back-pressure, or raises `lane_stall` to hide its queue head. The controller never drops or duplicates an instruction.

Top module: `simd_lane_issuer`

## Requirements
- R1: After reset, every lane occupancy is 0, every `lane_valid` is 0, `barrier_active` is 0, and `in_ready` is 1 for an instruction that needs no realignment.
- R2: An accepted instruction is appended to every lane queue at the same clock edge. Each lane occupancy then rises by one, less one for any lane that pops in that cycle.
- R3: Each lane presents instructions on `lane_instr` in the exact order they were accepted.
- R4: While `lane_stall[i]` is 1, `lane_valid[i]` is 0 and lane i's queue is not popped. Other lanes keep presenting and popping.
- R5: `lane_valid[i]` is 1 exactly when lane i's queue is non-empty and the lane is not stalled. The head is removed at a clock edge where `lane_valid[i]` and `lane_ready[i]` are both 1.
- R6: With the default queue depth of 4, `in_ready` is 0 whenever any lane queue holds 4 entries.
- R7: An instruction with `in_is_sync`=1 is accepted only when all lane queues are empty and no `lane_stall` bit is set. While such a valid instruction waits, `barrier_active` is 1.
- R8: With `sync_mode`=0, an instruction with `in_is_mem`=1 and `in_is_sync`=0 is accepted as soon as every queue has a free slot, without waiting for the lanes to drain.
- R9: With `sync_mode`=1, an instruction with `in_is_mem`=1 waits exactly like a synchronisation instruction. It raises `barrier_active` while it waits.
- R10: `lane_occ` reports each lane's queue occupancy. Lane i uses bits [3i+2:3i] at the default depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_mode | input | 1 | 0: realign only on sync instructions; 1: also realign before memory instructions |
| in_valid | input | 1 | Upstream instruction valid |
| in_ready | output | 1 | Controller can take the instruction this cycle |
| in_instr | input | INSTR_W | Instruction word |
| in_is_mem | input | 1 | Instruction is a load or store |
| in_is_sync | input | 1 | Instruction is an explicit synchronisation point |
| lane_valid | output | LANES | Per-lane head valid |
| lane_ready | input | LANES | Per-lane consumer ready |
| lane_instr | output | LANES*INSTR_W | Per-lane head instruction; lane i at [i*INSTR_W +: INSTR_W] |
| lane_stall | input | LANES | Per-lane local timing-error stall |
| lane_occ | output | LANES*OCC_W | Per-lane queue occupancy |
| barrier_active | output | 1 | A valid instruction is held waiting for realignment |

## Verification
`in_ready`, `barrier_active` and `lane_valid` respond in the same cycle to changes in the inputs and in queue state. An accepted instruction shows up at a lane head, and in `lane_occ`, in the cycle after the accepting edge. A pop is visible after that edge as well. The bench drives inputs just after the falling edge and lets them settle. It then compares every output against a queue-based model that holds the state as of the last rising edge. Only after that comparison does it advance the model by the handshakes of that cycle, so each result is checked in the exact cycle it is due.

// File: rtl/lane_issue_pkg.sv
package lane_issue_pkg;

  typedef enum logic {
    SYNC_EXPLICIT   = 1'b0,
    SYNC_BEFORE_MEM = 1'b1
  } sync_mode_e;

  function automatic logic needs_realign(sync_mode_e mode, logic is_mem, logic is_sync);
    return is_sync || ((mode == SYNC_BEFORE_MEM) && is_mem);
  endfunction

endpackage

// File: rtl/lane_ctl_fifo.sv
module lane_ctl_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 4,
  localparam int OCC_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             pop,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full,
  output logic [OCC_W-1:0] count
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] step(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      count <= count + OCC_W'(push) - OCC_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
  assign empty   = (count == '0);
  assign full    = (count == OCC_W'(DEPTH));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (int'(count) < DEPTH || pop));

  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));

  assert_count_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (int'(count) == int'($past(count)) + 1));

endmodule

// File: rtl/sync_gate.sv
module sync_gate
  import lane_issue_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             sync_mode,
  input  logic             in_valid,
  input  logic             in_is_mem,
  input  logic             in_is_sync,
  input  logic [LANES-1:0] lane_empty,
  input  logic [LANES-1:0] lane_full,
  input  logic [LANES-1:0] lane_stall,
  output logic             in_ready,
  output logic             barrier_active
);

  logic need, drained, space_all;

  always_comb begin
    need      = needs_realign(sync_mode_e'(sync_mode), in_is_mem, in_is_sync);
    drained   = (&lane_empty) && !(|lane_stall);
    space_all = !(|lane_full);
    in_ready       = space_all && (!need || drained);
    barrier_active = in_valid && need && !drained;
  end

endmodule

// File: rtl/simd_lane_issuer.sv
module simd_lane_issuer #(
  parameter int LANES      = 4,
  parameter int INSTR_W    = 16,
  parameter int FIFO_DEPTH = 4,
  localparam int OCC_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sync_mode,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [INSTR_W-1:0]       in_instr,
  input  logic                     in_is_mem,
  input  logic                     in_is_sync,
  output logic [LANES-1:0]         lane_valid,
  input  logic [LANES-1:0]         lane_ready,
  output logic [LANES*INSTR_W-1:0] lane_instr,
  input  logic [LANES-1:0]         lane_stall,
  output logic [LANES*OCC_W-1:0]   lane_occ,
  output logic                     barrier_active
);

  logic [LANES-1:0] q_empty, q_full, q_pop;
  logic [OCC_W-1:0] q_cnt [LANES];
  logic             accept;
  logic             all_zero;

  assign accept = in_valid && in_ready;

  sync_gate #(.LANES(LANES)) u_gate (
    .sync_mode      (sync_mode),
    .in_valid       (in_valid),
    .in_is_mem      (in_is_mem),
    .in_is_sync     (in_is_sync),
    .lane_empty     (q_empty),
    .lane_full      (q_full),
    .lane_stall     (lane_stall),
    .in_ready       (in_ready),
    .barrier_active (barrier_active)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_ctl_fifo #(.WIDTH(INSTR_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (accept),
      .wr_data (in_instr),
      .pop     (q_pop[g]),
      .rd_data (lane_instr[g*INSTR_W +: INSTR_W]),
      .empty   (q_empty[g]),
      .full    (q_full[g]),
      .count   (q_cnt[g])
    );

    assign lane_valid[g] = !q_empty[g] && !lane_stall[g];
    assign q_pop[g]      = lane_valid[g] && lane_ready[g];
    assign lane_occ[g*OCC_W +: OCC_W] = q_cnt[g];

    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_stall[g] |=> (q_cnt[g] >= $past(q_cnt[g])));
  end

  always_comb begin
    all_zero = 1'b1;
    for (int i = 0; i < LANES; i++) if (q_cnt[i] != '0) all_zero = 1'b0;
  end

  assert_sync_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_is_sync) |-> (all_zero && !(|lane_stall)));

  assert_mem_drained_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && sync_mode && in_is_mem) |-> all_zero);

endmodule

// File: tb/test_simd_lane_issuer.sv
`timescale 1ns/1ps
module test_simd_lane_issuer;

  localparam int N  = 4;
  localparam int IW = 16;
  localparam int D  = 4;
  localparam int OW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_mode = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IW-1:0] in_instr = '0;
  logic in_is_mem = 1'b0;
  logic in_is_sync = 1'b0;
  logic [N-1:0] lane_valid;
  logic [N-1:0] lane_ready = '0;
  logic [N*IW-1:0] lane_instr;
  logic [N-1:0] lane_stall = '0;
  logic [N*OW-1:0] lane_occ;
  logic barrier_active;

  int checks = 0;
  int errors = 0;
  logic [IW-1:0] q [N][$];

  always #10 clk = ~clk;

  simd_lane_issuer #(.LANES(N), .INSTR_W(IW), .FIFO_DEPTH(D)) i_simd_lane_issuer (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_instr(in_instr), .in_is_mem(in_is_mem),
    .in_is_sync(in_is_sync), .lane_valid(lane_valid), .lane_ready(lane_ready),
    .lane_instr(lane_instr), .lane_stall(lane_stall), .lane_occ(lane_occ),
    .barrier_active(barrier_active)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step_cycle();
    logic drained, space, need, exp_rdy, exp_bar, lv;
    string tag;
    #2;
    drained = (lane_stall == '0);
    space = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (q[i].size() != 0) drained = 1'b0;
      if (q[i].size() >= D) space = 1'b0;
    end
    need    = in_is_sync || (sync_mode && in_is_mem);
    exp_rdy = space && (!need || drained);
    exp_bar = in_valid && need && !drained;
    if (need) tag = in_is_sync ? "R7 sync wait" : "R9 mem wait";
    else if (!space) tag = "R6 full";
    else if (in_is_mem) tag = "R8 mem no wait";
    else tag = "R2 accept";
    chk(tag, in_ready, exp_rdy);
    chk(in_is_sync ? "R7 barrier flag" : "R9 barrier flag", barrier_active, exp_bar);
    for (int i = 0; i < N; i++) begin
      lv = (q[i].size() != 0) && !lane_stall[i];
      chk(lane_stall[i] ? "R4 stalled valid" : "R5 valid", lane_valid[i], lv);
      chk("R10 occupancy", lane_occ[i*OW +: OW], q[i].size());
      if (lv) chk("R3 order", lane_instr[i*IW +: IW], q[i][0]);
    end
    for (int i = 0; i < N; i++)
      if ((q[i].size() != 0) && !lane_stall[i] && lane_ready[i]) void'(q[i].pop_front());
    if (in_valid && exp_rdy)
      for (int i = 0; i < N; i++) q[i].push_back(in_instr);
    @(negedge clk);
  endtask

  task automatic run_phase(int cycles, logic mode, int pv, int ps, int pm, int pst, int prd);
    sync_mode = mode;
    for (int c = 0; c < cycles; c++) begin
      if (!(in_valid && !in_ready)) begin
        in_valid   = ($urandom % 100) < pv;
        in_instr   = IW'($urandom);
        in_is_sync = ($urandom % 100) < ps;
        in_is_mem  = ($urandom % 100) < pm;
      end
      for (int i = 0; i < N; i++) begin
        lane_stall[i] = ($urandom % 100) < pst;
        lane_ready[i] = ($urandom % 100) < prd;
      end
      step_cycle();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1 reset ready", in_ready, 1);
    chk("R1 reset barrier", barrier_active, 0);
    chk("R1 reset valid", lane_valid, 0);
    chk("R1 reset occ", lane_occ, 0);
    @(negedge clk);
    run_phase(300, 1'b0, 90, 0, 0, 0, 20);
    run_phase(600, 1'b0, 70, 0, 20, 30, 70);
    run_phase(600, 1'b0, 70, 15, 30, 10, 70);
    run_phase(600, 1'b1, 70, 0, 30, 10, 70);
    run_phase(600, 1'b0, 80, 0, 40, 5, 60);
    run_phase(600, 1'b1, 70, 10, 30, 15, 80);
    in_valid = 1'b0;
    lane_stall = '0;
    lane_ready = '1;
    for (int c = 0; c < 12; c++) step_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule